// File: doc/BRIEF.md
# Command-Sequence Write Protection Controller

This block sits between a host byte-write port and a byte-wide nonvolatile array that has a page buffer. It decides which host writes reach the array. Protection is held in a single sticky bit, modelled here as a register. The bit is set and cleared only by fixed multi-write command sequences that the host issues, never by a pin. After reset the bit is clear, and every host write passes straight through to the array as a plain byte write.

Once protection is on, a lone write is dropped. To make an authorized update, the host repeats the three-write arm sequence and then streams up to one page of bytes. All of those bytes must lie in the page chosen by the first byte. When the host stops writing for a set number of cycles, the block fires a commit strobe and reports busy for one write-cycle time. Protection then stays on with no further command. A longer six-write sequence clears the bit. Setting or clearing the bit also takes one busy write-cycle time, and the change is seen only when busy drops.

The command addresses and data, the page size, the load timeout and the write-cycle time are all parameters.

Top module: `sdp_write_ctrl`

## Requirements
- R1: After reset, prot_o, busy_o, arr_we_o and commit_o are all 0.
- R2: While unprotected and not busy, every host write appears as a one-cycle arr_we_o pulse in the cycle after the write, carrying that write's address and data. This includes writes that match part or all of a command sequence.
- R3: The arm sequence is three consecutive writes: 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0. While unprotected, completing it raises busy_o in the cycle after the third write and holds it for TWC cycles. prot_o goes to 1 in the same cycle that busy_o falls.
- R4: While protected, a write that does not complete the arm sequence produces no arr_we_o pulse.
- R5: A write that breaks a partial sequence sends the detector back to its start. If that breaking write equals the first step of the sequence, it counts as step one.
- R6: While protected, completing the arm sequence opens a load window and the third write itself is not passed. The first write in the window picks the page, which is the address bits above the low log2(PAGE_BYTES) bits. In-page writes pulse arr_we_o in the next cycle, and writes to any other page are dropped.
- R7: A load window accepts at most PAGE_BYTES bytes, and any further writes are dropped.
- R8: When LOAD_TO cycles pass with no write after the last write of a window that holds at least one byte, commit_o pulses for one cycle. busy_o rises in that same cycle and stays high for TWC cycles, and prot_o stays 1.
- R9: A load window that receives no write within LOAD_TO cycles closes with no commit. Later lone writes are again dropped.
- R10: The clear sequence is six writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. Completing it raises busy_o for TWC cycles, and prot_o goes to 0 as busy_o falls.
- R11: Host writes made while busy_o is high produce no arr_we_o pulse and do not advance any sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe, one write per high cycle |
| addr_i | input | AW | Host write address |
| data_i | input | 8 | Host write data |
| arr_we_o | output | 1 | Byte write or page-buffer load enable to the array |
| arr_addr_o | output | AW | Address that goes with arr_we_o |
| arr_data_o | output | 8 | Data that goes with arr_we_o |
| commit_o | output | 1 | One-cycle pulse that starts a page program |
| busy_o | output | 1 | A write cycle or a protection change is in progress |
| prot_o | output | 1 | Current state of the sticky protection bit |

## Verification
A passed byte shows on arr_we_o one clock after the edge that takes the write. The bench drives each write at a falling edge and reads the outputs at the next falling edge, which lands exactly one register stage later. The commit pulse is due LOAD_TO cycles after the last window write, and busy lasts TWC cycles from the cycle after the completing write or from the commit. The bench counts falling edges from the stimulus until each of these events and compares the count with the parameter, so a result that comes one cycle early or late is reported. The protection bit is checked only once busy has dropped, the first cycle in which it is allowed to change.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int DW = 8;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_BUSY} sdp_st_e;
  typedef enum logic [1:0] {PD_NONE, PD_SET, PD_CLR} sdp_pend_e;
endpackage

// File: rtl/sdp_seq_match.sv
module sdp_seq_match #(
  parameter int AW  = 16,
  parameter int LEN = 3,
  parameter logic [LEN*AW-1:0] ADDRS = '0,
  parameter logic [LEN*8-1:0]  DATAS = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          hit_o
);
  localparam int SW = (LEN > 1) ? $clog2(LEN) : 1;
  logic [SW-1:0] step_q;
  logic match_cur, match_first, last;

  assign match_cur   = (addr_i == ADDRS[step_q*AW +: AW]) && (data_i == DATAS[step_q*8 +: 8]);
  assign match_first = (addr_i == ADDRS[AW-1:0]) && (data_i == DATAS[7:0]);
  assign last        = (step_q == SW'(LEN-1));
  assign hit_o       = wr_i && !clr_i && match_cur && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          step_q <= '0;
    else if (clr_i)       step_q <= '0;
    else if (wr_i) begin
      if (match_cur)      step_q <= last ? '0 : step_q + 1'b1;
      else                step_q <= match_first ? SW'(1) : '0;  // restart on step one
    end
  end
endmodule

// File: rtl/sdp_page_win.sv
module sdp_page_win #(
  parameter int AW         = 16,
  parameter int PAGE_BYTES = 128,
  parameter int LOAD_TO    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  input  logic          act_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          take_o,
  output logic          expire_o,
  output logic          any_o
);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int PW = AW - OW;
  localparam int CW = (LOAD_TO > 1) ? $clog2(LOAD_TO) : 1;
  localparam int NW = $clog2(PAGE_BYTES + 1);

  logic [CW-1:0] tmo_q;
  logic [NW-1:0] nbytes_q;
  logic [PW-1:0] page_q;
  logic          in_page, room;

  assign in_page  = (nbytes_q == '0) || (addr_i[AW-1:OW] == page_q);
  assign room     = (nbytes_q < NW'(PAGE_BYTES));
  assign take_o   = act_i && wr_i && in_page && room;
  assign expire_o = act_i && !wr_i && (tmo_q == '0);
  assign any_o    = (nbytes_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q    <= '0;
      nbytes_q <= '0;
      page_q   <= '0;
    end else if (open_i) begin
      tmo_q    <= CW'(LOAD_TO-1);
      nbytes_q <= '0;
    end else if (act_i && wr_i) begin
      tmo_q <= CW'(LOAD_TO-1);
      if (take_o) begin
        nbytes_q <= nbytes_q + 1'b1;
        if (nbytes_q == '0) page_q <= addr_i[AW-1:OW];
      end
    end else if (act_i && tmo_q != '0) begin
      tmo_q <= tmo_q - 1'b1;
    end
  end
endmodule

// File: rtl/sdp_busy_tmr.sv
module sdp_busy_tmr #(
  parameter int TWC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = (TWC > 1) ? $clog2(TWC) : 1;
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(TWC-1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sdp_write_ctrl.sv
module sdp_write_ctrl #(
  parameter int AW         = 16,
  parameter int PAGE_BYTES = 128,
  parameter int LOAD_TO    = 16,
  parameter int TWC        = 32,
  parameter logic [3*AW-1:0] EN_ADDR  = {16'h5555, 16'h2AAA, 16'h5555},
  parameter logic [23:0]     EN_DATA  = {8'hA0, 8'h55, 8'hAA},
  parameter logic [6*AW-1:0] DIS_ADDR = {16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555},
  parameter logic [47:0]     DIS_DATA = {8'h20, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [7:0]    arr_data_o,
  output logic          commit_o,
  output logic          busy_o,
  output logic          prot_o
);
  import sdp_pkg::*;

  sdp_st_e   st_q, st_d;
  sdp_pend_e pend_q, pend_d;
  logic prot_q, prot_d;
  logic pass, commit_d, go_busy, open_win;
  logic en_hit, dis_hit, take, expire, any, tmr_done, seq_clr;

  assign seq_clr = (st_q != ST_IDLE);

  sdp_seq_match #(.AW(AW), .LEN(3), .ADDRS(EN_ADDR), .DATAS(EN_DATA)) i_en_seq (
    .clk_i, .rst_ni, .clr_i(seq_clr), .wr_i, .addr_i, .data_i, .hit_o(en_hit));

  sdp_seq_match #(.AW(AW), .LEN(6), .ADDRS(DIS_ADDR), .DATAS(DIS_DATA)) i_dis_seq (
    .clk_i, .rst_ni, .clr_i(seq_clr), .wr_i, .addr_i, .data_i, .hit_o(dis_hit));

  sdp_page_win #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .LOAD_TO(LOAD_TO)) i_win (
    .clk_i, .rst_ni, .open_i(open_win), .act_i(st_q == ST_LOAD), .wr_i, .addr_i,
    .take_o(take), .expire_o(expire), .any_o(any));

  sdp_busy_tmr #(.TWC(TWC)) i_tmr (
    .clk_i, .rst_ni, .start_i(go_busy), .done_o(tmr_done));

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    prot_d   = prot_q;
    pass     = 1'b0;
    commit_d = 1'b0;
    go_busy  = 1'b0;
    open_win = 1'b0;
    unique case (st_q)
      ST_IDLE: if (wr_i) begin
        pass = !prot_q && !(en_hit && prot_q);
        if (en_hit && prot_q) begin
          st_d = ST_LOAD; open_win = 1'b1;
        end else if (en_hit) begin
          st_d = ST_BUSY; go_busy = 1'b1; pend_d = PD_SET;
        end else if (dis_hit) begin
          st_d = ST_BUSY; go_busy = 1'b1; pend_d = PD_CLR;
        end
      end
      ST_LOAD: begin
        pass = take;
        if (expire) begin
          if (any) begin
            st_d = ST_BUSY; go_busy = 1'b1; commit_d = 1'b1; pend_d = PD_NONE;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_BUSY: if (tmr_done) begin
        st_d = ST_IDLE;
        if (pend_q == PD_SET) prot_d = 1'b1;
        if (pend_q == PD_CLR) prot_d = 1'b0;
        pend_d = PD_NONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      pend_q     <= PD_NONE;
      prot_q     <= 1'b0;
      arr_we_o   <= 1'b0;
      arr_addr_o <= '0;
      arr_data_o <= '0;
      commit_o   <= 1'b0;
    end else begin
      st_q     <= st_d;
      pend_q   <= pend_d;
      prot_q   <= prot_d;
      arr_we_o <= pass;
      commit_o <= commit_d;
      if (pass) begin
        arr_addr_o <= addr_i;
        arr_data_o <= data_i;
      end
    end
  end

  assign busy_o = (st_q == ST_BUSY);
  assign prot_o = prot_q;
endmodule

// File: rtl/sdp_write_ctrl_chk.sv
module sdp_write_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic idle_i,
  input logic arr_we_o,
  input logic commit_o,
  input logic busy_o,
  input logic prot_o
);
  // R11
  busy_blocks_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !arr_we_o);
  // R8
  commit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> busy_o);
  // R8
  commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  // R3
  prot_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prot_o) |-> $fell(busy_o));
  // R4
  locked_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_o && idle_i && wr_i) |=> !arr_we_o);
endmodule

bind sdp_write_ctrl sdp_write_ctrl_chk i_chk (
  .clk_i, .rst_ni, .wr_i,
  .idle_i(st_q == sdp_pkg::ST_IDLE),
  .arr_we_o, .commit_o, .busy_o, .prot_o);

// File: tb/test_sdp_write_ctrl.sv
module test_sdp_write_ctrl;
  localparam int AW = 16, PAGE = 128, LTO = 16, TWC = 32;

  logic clk = 0, rst_n = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic we, commit, busy, prot;
  logic [AW-1:0] waddr;
  logic [7:0] wdata;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sdp_write_ctrl #(.AW(AW), .PAGE_BYTES(PAGE), .LOAD_TO(LTO), .TWC(TWC)) i_sdp_write_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .arr_we_o(we), .arr_addr_o(waddr), .arr_data_o(wdata),
    .commit_o(commit), .busy_o(busy), .prot_o(prot));

  // {addr, data}: unprotected writes, incl. partial command prefixes (R2)
  localparam logic [23:0] VEC [6] = '{
    {16'h5555, 8'hAA}, {16'h2AAA, 8'h55}, {16'h1234, 8'h77},
    {16'h0000, 8'h00}, {16'hFFFF, 8'hFF}, {16'h5555, 8'hA0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [AW-1:0] a, input logic [7:0] d);
    wr = 1; addr = a; data = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic arm();
    hw(16'h5555, 8'hAA); hw(16'h2AAA, 8'h55); hw(16'h5555, 8'hA0);
  endtask

  task automatic disarm();
    hw(16'h5555, 8'hAA); hw(16'h2AAA, 8'h55); hw(16'h5555, 8'h80);
    hw(16'h5555, 8'hAA); hw(16'h2AAA, 8'h55); hw(16'h5555, 8'h20);
  endtask

  // counts cycles busy stays high, starting at current negedge
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n, k, cnt;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 prot", prot, 0); chk("R1 busy", busy, 0);
    chk("R1 we", we, 0); chk("R1 commit", commit, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 vector walk
    for (int i = 0; i < 6; i++) begin
      hw(VEC[i][23:8], VEC[i][7:0]);
      chk("R2 we", we, 1);
      chk("R2 addr/data", {waddr, wdata}, VEC[i]);
    end
    @(negedge clk);
    chk("R2 no busy after broken prefix", busy, 0);

    // R3 arm while unprotected: writes pass, busy TWC, prot on fall
    arm();
    chk("R2 arm write passes", {we, waddr, wdata}, {1'b1, 16'h5555, 8'hA0});
    chk("R3 busy rise", busy, 1);
    chk("R3 prot not yet", prot, 0);
    // R11 write during busy ignored
    hw(16'h1111, 8'h11);
    chk("R11 busy drop", we, 0);
    busy_len(n);
    chk("R3 busy length", n, TWC - 1);
    chk("R3 prot set", prot, 1);

    // R4 lone write dropped
    hw(16'h0100, 8'h5A);
    chk("R4 locked write", we, 0);
    @(negedge clk);
    chk("R4 no window busy", busy, 0);

    // R5 plain mismatch: no window
    hw(16'h5555, 8'hAA); hw(16'h2AAA, 8'h55); hw(16'h1234, 8'h00);
    hw(16'h5555, 8'hA0);
    hw(16'h0200, 8'h66);
    chk("R5 broken seq no pass", we, 0);

    // R5 restart on step-one match, then R6 page select/drop, R8 commit
    hw(16'h5555, 8'hAA); hw(16'h2AAA, 8'h55); hw(16'h5555, 8'hAA);
    hw(16'h2AAA, 8'h55); hw(16'h5555, 8'hA0);
    chk("R6 arm write not passed", we, 0);
    hw(16'h0300, 8'h11);
    chk("R5 restart opens window", {we, waddr, wdata}, {1'b1, 16'h0300, 8'h11});
    hw(16'h0305, 8'h22);
    chk("R6 in-page", {we, waddr, wdata}, {1'b1, 16'h0305, 8'h22});
    hw(16'h0400, 8'h33);
    chk("R6 other page dropped", we, 0);
    k = 0;
    while (!commit && k < 200) begin @(negedge clk); k++; end
    chk("R8 commit delay", k, LTO);
    chk("R8 busy with commit", busy, 1);
    @(negedge clk);
    chk("R8 commit one cycle", commit, 0);
    busy_len(n);
    chk("R8 busy length", n, TWC - 1);
    chk("R8 prot kept", prot, 1);
    hw(16'h0300, 8'h99);
    chk("R8 relocked", we, 0);

    // R9 empty window
    arm();
    repeat (LTO + 2) @(negedge clk);
    hw(16'h0500, 8'h44);
    chk("R9 window closed", we, 0);
    cnt = 0;
    repeat (LTO + 4) begin @(negedge clk); if (commit || busy) cnt++; end
    chk("R9 no commit", cnt, 0);

    // R7 page limit
    arm();
    cnt = 0;
    for (int j = 0; j < PAGE + 1; j++) begin
      hw(16'h0700 | AW'(j % PAGE), 8'(j));
      if (we) cnt++;
    end
    chk("R7 bytes loaded", cnt, PAGE);
    k = 0;
    while (!commit && k < 200) begin @(negedge clk); k++; end
    chk("R7 commit after full page", commit, 1);
    @(negedge clk);
    busy_len(n);

    // R10 clear sequence
    disarm();
    chk("R10 locked seq not passed", we, 0);
    chk("R10 busy rise", busy, 1);
    chk("R10 prot still on", prot, 1);
    busy_len(n);
    chk("R10 busy length", n, TWC);
    chk("R10 prot cleared", prot, 0);
    hw(16'h0800, 8'hC3);
    chk("R10 open access", {we, waddr, wdata}, {1'b1, 16'h0800, 8'hC3});

    finish_run();
  end
endmodule